// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block finds which DRAM chip-select row holds a given physical address. Software programs one boundary byte per row through a small write port. Each byte gives the cumulative end of its row in 64 MiB units, so a row covers the span from the boundary below it (zero for row 0) up to, but not including, its own boundary. A row whose boundary equals the one below it holds no memory, and the decoder never selects it.

A 32-bit mode word comes in from the controller's configuration. Its channel bit picks between single-channel use, where all eight rows count, and dual-channel use, where only the lower half of the rows count. Each address given with a valid strobe produces, one clock later, a row index, a hit flag and an out-of-range flag. An address that lies at or above the top boundary of the active rows is reported as out of range.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary register holds zero and `res_valid`, `res_row`, `res_hit` and `res_oor` are all zero. Until software programs a boundary, every lookup reports out of range.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]` into the boundary register chosen by `cfg_idx` at the next rising edge. Bit 7 is reserved and is not stored. `cfg_rdata` returns the register chosen by `cfg_idx`, with bit 7 reading as 0.
- R3: The 64 MiB unit of an address is `addr >> 26`. Row i is selected when that unit is at least the boundary of row i-1 (zero for row 0) and strictly less than the boundary of row i.
- R4: When several rows qualify, the lowest-indexed row wins. A row whose boundary equals the previous row's boundary is never reported as a hit.
- R5: `mode_word[21]` = 0 selects single-channel mode, where rows 0 to 7 are active. `mode_word[21]` = 1 selects dual-channel mode, where only rows 0 to 3 are active and the values in rows 4 to 7 have no effect on any lookup.
- R6: An address whose unit is at or above the boundary of the last active row (row 7 in single-channel mode, row 3 in dual-channel mode) gives `res_oor`=1, `res_hit`=0 and `res_row`=0.
- R7: `res_valid` is high exactly in the cycle after `addr_valid` was sampled high, and the result reflects the address and mode sampled at that edge. While `addr_valid` is low, `res_row`, `res_hit` and `res_oor` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Boundary register write enable |
| cfg_idx | input | 3 | Boundary register index for write and read |
| cfg_wdata | input | 8 | Write data; bit 7 reserved |
| cfg_rdata | output | 8 | Read data of the indexed boundary register |
| mode_word | input | 32 | Controller mode word; bit 21 selects dual channel |
| addr_valid | input | 1 | Lookup strobe |
| addr | input | 36 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_row | output | 3 | Selected row index |
| res_hit | output | 1 | Address lies in a populated active row |
| res_oor | output | 1 | Address lies at or above the top active boundary |

## Verification
The assertions check four rules on every cycle. The result strobe trails the lookup strobe by exactly one cycle. A reported hit lies strictly below its row's boundary and at or above the boundary beneath it. A hit never lands on an empty row. In dual-channel mode a hit never lands in the upper half of the rows. Other behaviour only shows up in the bench's scenarios, because it depends on what software programmed: lowest-index priority, the exact out-of-range threshold in each mode, reserved-bit masking on writes, the all-zero state after reset, and outputs holding their values between lookups.

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int ROWS       = 8,
  parameter int BW         = 7,
  parameter int ADDR_W     = 36,
  parameter int UNIT_SHIFT = 26,
  parameter int MODE_BIT   = 21,
  parameter int IW         = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [31:0]       mode_word,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              res_valid,
  output logic [IW-1:0]     res_row,
  output logic              res_hit,
  output logic              res_oor
);
  localparam int UW   = ADDR_W - UNIT_SHIFT;
  localparam int CW   = (UW > BW) ? UW : BW;
  localparam int HALF = ROWS / 2;

  logic [BW-1:0] bnd    [ROWS];
  logic [BW-1:0] prev_b [ROWS];
  logic [ROWS-1:0] cand;
  logic [CW-1:0] unit_x;
  logic          dual;
  logic [BW-1:0] top_b;
  logic          oor_c;
  logic          found_c;
  logic [IW-1:0] row_c;

  assign unit_x = CW'(addr[ADDR_W-1:UNIT_SHIFT]);
  assign dual   = mode_word[MODE_BIT];
  assign top_b  = dual ? bnd[HALF-1] : bnd[ROWS-1];
  assign oor_c  = unit_x >= CW'(top_b);
  assign found_c = |cand;
  assign cfg_rdata = 8'(bnd[cfg_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) bnd[i] <= '0;
    end else if (cfg_we) begin
      bnd[cfg_idx] <= cfg_wdata[BW-1:0];
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    if (g == 0) begin : g_first
      assign prev_b[g] = '0;
    end else begin : g_rest
      assign prev_b[g] = bnd[g-1];
    end
    assign cand[g] = ((g < HALF) || !dual)
                   && (CW'(bnd[g]) > unit_x)
                   && (bnd[g] != prev_b[g]);
  end

  always_comb begin
    row_c = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (cand[i]) row_c = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_hit   <= 1'b0;
      res_oor   <= 1'b0;
    end else begin
      res_valid <= addr_valid;
      if (addr_valid) begin
        res_hit <= found_c && !oor_c;
        res_oor <= oor_c;
        res_row <= (found_c && !oor_c) ? row_c : '0;
      end
    end
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(addr_valid));

  a_r5_dual_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && $past(mode_word[MODE_BIT])) |-> (res_row < IW'(HALF)));

  a_r3_below_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !$past(cfg_we))
      |-> ($past(unit_x) < CW'(bnd[res_row]) && $past(unit_x) >= CW'(prev_b[res_row])));

  a_r4_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !$past(cfg_we)) |-> (bnd[res_row] != prev_b[res_row]));
endmodule

// File: tb/tb_dram_row_decoder.sv
module tb_dram_row_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] mode_word = '0;
  logic        addr_valid = 1'b0;
  logic [35:0] addr = '0;
  logic        res_valid;
  logic [2:0]  res_row;
  logic        res_hit;
  logic        res_oor;

  int checks = 0;
  int errors = 0;
  logic [6:0] mb [8];
  logic [4:0] expq [$];
  logic [4:0] last_exp = '0;

  always #4 clk = ~clk;

  dram_row_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_word(mode_word),
    .addr_valid(addr_valid), .addr(addr), .res_valid(res_valid),
    .res_row(res_row), .res_hit(res_hit), .res_oor(res_oor));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model(int unit, bit dual);
    int n = dual ? 4 : 8;
    int top = mb[n-1];
    int prev;
    if (unit >= top) return {3'd0, 1'b0, 1'b1};
    for (int i = 0; i < n; i++) begin
      prev = (i == 0) ? 0 : mb[i-1];
      if (mb[i] > unit && mb[i] != prev) return {3'(i), 1'b1, 1'b0};
    end
    return {3'd0, 1'b0, 1'b0};
  endfunction

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mb[idx] = d[6:0];
  endtask

  task automatic look(int unit, int off, bit dual);
    @(negedge clk);
    mode_word = dual ? 32'h0020_0000 : 32'h0000_0000;
    addr_valid = 1'b1;
    addr = (36'(unit) << 26) | 36'(off);
    expq.push_back(model(unit, dual));
  endtask

  task automatic drain();
    @(negedge clk);
    addr_valid = 1'b0;
    mode_word = 32'hFFDF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R7 idle valid", 32'(res_valid), 0);
    chk("R7 hold", 32'({res_row, res_hit, res_oor}), 32'(last_exp));
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: result without lookup, actual 1 expected 0");
      end else begin
        last_exp = expq.pop_front();
        chk("R3/R4/R5/R6 lookup", 32'({res_row, res_hit, res_oor}), 32'(last_exp));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mb[i] = '0;
    #20;
    chk("R1 reset outputs", 32'({res_valid, res_row, res_hit, res_oor}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); cfg_idx = 3'(i); #1;
      chk("R1 reset boundary", 32'(cfg_rdata), 0);
    end
    look(0, 0, 0);
    drain();
    chk("R1 unprogrammed oor", 32'(res_oor), 1);

    wr(0, 8'h85);
    @(negedge clk); cfg_idx = 3'd0; #1;
    chk("R2 reserved bit", 32'(cfg_rdata), 32'h05);

    wr(0, 8'd2); wr(1, 8'd4); wr(2, 8'd4); wr(3, 8'd7);
    wr(4, 8'd7); wr(5, 8'd7); wr(6, 8'd9); wr(7, 8'd12);
    @(negedge clk); cfg_idx = 3'd6; #1;
    chk("R2 readback", 32'(cfg_rdata), 9);

    look(0, 0, 0);
    look(1, 32'h3FF_FFFF, 0);
    look(2, 0, 0);
    look(3, 5, 0);
    look(4, 0, 0);
    look(6, 1, 0);
    look(7, 0, 0);
    look(8, 0, 0);
    look(11, 7, 0);
    look(12, 0, 0);
    look(13, 0, 0);
    look(900, 0, 0);
    drain();

    look(0, 0, 1);
    look(6, 0, 1);
    look(7, 0, 1);
    look(8, 0, 1);
    look(11, 0, 1);
    drain();

    wr(7, 8'd100);
    look(50, 0, 1);
    look(50, 0, 0);
    drain();

    for (int i = 0; i < 7; i++) wr(i, 8'd0);
    wr(7, 8'd10);
    look(3, 0, 0);
    look(10, 0, 0);
    look(3, 0, 1);
    drain();
    chk("R5 dual all empty", 32'({res_hit, res_oor}), 32'b01);

    wr(0, 8'd5); wr(1, 8'd3); wr(2, 8'd3); wr(3, 8'd8);
    look(2, 0, 1);
    look(4, 0, 1);
    look(6, 0, 1);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule